// File: doc/BRIEF.md
# Interrupt context stacking sequencer

This block sits beside a small 8-bit CPU core with 16-bit addressing and carries out the memory traffic of interrupt entry and interrupt return. The core raises an interrupt request only at an instruction boundary, so the instruction in flight has already finished. On acceptance the sequencer captures the program counter, both index registers, both accumulators, the condition codes and the stack pointer. It writes them byte by byte to a descending stack, one byte per clock, with the return address first. It then reads a two-byte vector, high byte first, and presents the vector as the new program counter.

A return request pulls the same nine bytes back in exactly the reverse order and leaves the restored return address on the program counter output. The stack pointer addresses the next free byte. It is decremented after each write and incremented before each read, and all address arithmetic wraps modulo 2^16. A busy flag covers the whole operation. A one-cycle done pulse tells the core that the register outputs and the stack pointer output now hold the result.

Top module: `irq_stacker`

## Requirements
- R1: A request is accepted only while the sequencer is idle (busy low). If the interrupt request and the return request are both high in the same idle cycle, the interrupt is taken.
- R2: After an interrupt is accepted, nine write cycles follow back to back, one byte each. The bytes go out in the order PC[7:0], PC[15:8], Y[7:0], Y[15:8], X[7:0], X[15:8], A, B, CCR.
- R3: Push number k (k = 0..8) is written at address SP-k, where SP is the captured stack pointer. After the interrupt, sp_out equals SP-9.
- R4: After the pushes, two read cycles fetch the vector: the high byte at irq_vec and the low byte at irq_vec+1. At done, pc_out equals {high, low}.
- R5: For an interrupt, busy is high for exactly 11 cycles (9 pushes plus 2 vector reads). done is high for the one cycle after that, with busy low. done is never high while busy is high.
- R6: After a return request, nine read cycles follow at addresses SP+1 through SP+9. They restore CCR, B, A, X[15:8], X[7:0], Y[15:8], Y[7:0], PC[15:8], PC[7:0] in that order. Busy is high for exactly 9 cycles, and afterwards sp_out equals SP+9.
- R7: Interrupt or return requests raised while busy is high have no effect. No extra memory cycle occurs, and busy falls on schedule.
- R8: While reset is held, busy, done and mem_we are low.
- R9: After an interrupt, y_out, x_out, a_out, b_out and ccr_out equal the values captured at acceptance.
- R10: Stack and vector addresses wrap modulo 2^16. mem_we is high only while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request, sampled while idle |
| irq_vec | input | 16 | Address of the two-byte vector |
| rti_req | input | 1 | Return-from-interrupt request |
| pc_in | input | 16 | Program counter to save |
| y_in | input | 16 | Y index register to save |
| x_in | input | 16 | X index register to save |
| a_in | input | 8 | Accumulator A to save |
| b_in | input | 8 | Accumulator B to save |
| ccr_in | input | 8 | Condition codes to save |
| sp_in | input | 16 | Stack pointer at acceptance |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as mem_addr |
| mem_we | output | 1 | Memory write enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the results are valid |
| pc_out | output | 16 | Vector (after an interrupt) or restored PC (after a return) |
| y_out | output | 16 | Y result |
| x_out | output | 16 | X result |
| a_out | output | 8 | A result |
| b_out | output | 8 | B result |
| ccr_out | output | 8 | CCR result |
| sp_out | output | 16 | Stack pointer after the sequence |

## Verification
The bench builds the block with its default parameters: 16-bit addresses and 8-bit data, which gives a nine-byte frame. Every byte of every frame is checked against the expected address and value. Stack pointers are chosen so that the frame crosses address zero, and one vector sits at the top of memory so that its low byte comes from address zero. Each interrupt is followed by a return that restores the frame. Some runs also drive both requests in the same idle cycle, or drive requests in the middle of a busy sequence.

// File: rtl/irq_stk_pkg.sv
package irq_stk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VEC  = 2'd2,
    ST_PULL = 2'd3
  } stk_state_t;
endpackage

// File: rtl/irq_stk_ctrl.sv
module irq_stk_ctrl
  import irq_stk_pkg::*;
#(
  parameter int FRAME_BYTES = 9,
  parameter int VEC_BYTES   = 2,
  parameter int CW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic          rti_req,
  output logic          take_irq,
  output logic          take_rti,
  output logic          in_push,
  output logic          in_vec,
  output logic          in_pull,
  output logic [CW-1:0] step,
  output logic          busy,
  output logic          done
);
  localparam logic [CW-1:0] LAST_FRAME = CW'(FRAME_BYTES - 1);
  localparam logic [CW-1:0] LAST_VEC   = CW'(VEC_BYTES - 1);

  stk_state_t state_q, state_d;
  logic [CW-1:0] step_q, step_d;
  logic done_q, done_d;

  assign take_irq = (state_q == ST_IDLE) && irq_req;
  assign take_rti = (state_q == ST_IDLE) && !irq_req && rti_req;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        step_d = '0;
        if (take_irq)      state_d = ST_PUSH;
        else if (take_rti) state_d = ST_PULL;
      end
      ST_PUSH: begin
        if (step_q == LAST_FRAME) begin
          state_d = ST_VEC;
          step_d  = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_VEC: begin
        if (step_q == LAST_VEC) begin
          state_d = ST_IDLE;
          step_d  = '0;
          done_d  = 1'b1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      ST_PULL: begin
        if (step_q == LAST_FRAME) begin
          state_d = ST_IDLE;
          step_d  = '0;
          done_d  = 1'b1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done_q  <= done_d;
    end
  end

  assign in_push = (state_q == ST_PUSH);
  assign in_vec  = (state_q == ST_VEC);
  assign in_pull = (state_q == ST_PULL);
  assign step    = step_q;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_push, in_vec, in_pull})); // R1
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_push || (busy && step != LAST_FRAME && !in_vec)) |=> busy); // R7
  AST_PUSH_TO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_push && step == LAST_FRAME) |=> in_vec); // R4
endmodule

// File: rtl/irq_stk_addr.sv
module irq_stk_addr #(
  parameter int AW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_irq,
  input  logic          take_rti,
  input  logic          in_push,
  input  logic          in_vec,
  input  logic          in_pull,
  input  logic [CW-1:0] step,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] vec_in,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] sp_out
);
  logic [AW-1:0] sp_q, sp_d;
  logic [AW-1:0] vec_q;
  logic          sp_en, vec_en;

  assign sp_en  = take_irq || take_rti || in_push || in_pull;
  assign vec_en = take_irq;

  always_comb begin
    sp_d = sp_q;
    if (take_irq || take_rti) sp_d = sp_in;
    else if (in_push)         sp_d = sp_q - 1'b1;
    else if (in_pull)         sp_d = sp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      vec_q <= '0;
    end else begin
      if (sp_en)  sp_q  <= sp_d;
      if (vec_en) vec_q <= vec_in;
    end
  end

  always_comb begin
    mem_addr = '0;
    if (in_push)      mem_addr = sp_q;
    else if (in_pull) mem_addr = sp_q + 1'b1;
    else if (in_vec)  mem_addr = vec_q + AW'(step);
  end

  assign sp_out = sp_q;

  AST_PUSH_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_push && $past(in_push)) |-> mem_addr == $past(mem_addr) - 1'b1); // R3
  AST_PULL_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pull && $past(in_pull)) |-> mem_addr == $past(mem_addr) + 1'b1); // R6
  AST_VEC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vec && $past(in_vec)) |-> mem_addr == $past(mem_addr) + 1'b1); // R4
endmodule

// File: rtl/irq_stk_ctx.sv
module irq_stk_ctx #(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int FRAME_BYTES = 9,
  parameter int CW          = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take_irq,
  input  logic                     in_push,
  input  logic                     in_vec,
  input  logic                     in_pull,
  input  logic [CW-1:0]            step,
  input  logic [FRAME_BYTES*DW-1:0] frame_in,
  input  logic [DW-1:0]            rdata,
  output logic [DW-1:0]            wdata,
  output logic                     we,
  output logic [FRAME_BYTES*DW-1:0] frame_out
);
  localparam int WPB = AW / DW;

  logic [DW-1:0] byte_q [FRAME_BYTES];

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_byte
    logic          pull_hit, vec_hit, en;
    logic [DW-1:0] nxt;
    assign pull_hit = in_pull && (step == CW'(FRAME_BYTES - 1 - g));
    if (g < WPB) begin : g_pc
      assign vec_hit = in_vec && (step == CW'(WPB - 1 - g));
    end else begin : g_other
      assign vec_hit = 1'b0;
    end
    assign en  = take_irq || pull_hit || vec_hit;
    assign nxt = take_irq ? frame_in[g*DW +: DW] : rdata;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q[g] <= '0;
      else if (en) byte_q[g] <= nxt;
    end
    assign frame_out[g*DW +: DW] = byte_q[g];
  end

  assign we    = in_push;
  assign wdata = in_push ? byte_q[step] : '0;

  AST_WRITE_ONLY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !(in_pull || in_vec)); // R10
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_push |=> $stable(frame_out)); // R2
endmodule

// File: rtl/irq_stacker.sv
module irq_stacker #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic [AW-1:0] irq_vec,
  input  logic          rti_req,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] y_in,
  input  logic [AW-1:0] x_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic [DW-1:0] ccr_in,
  input  logic [AW-1:0] sp_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic [AW-1:0] y_out,
  output logic [AW-1:0] x_out,
  output logic [DW-1:0] a_out,
  output logic [DW-1:0] b_out,
  output logic [DW-1:0] ccr_out,
  output logic [AW-1:0] sp_out
);
  localparam int WPB         = AW / DW;
  localparam int FRAME_BYTES = 3 * WPB + 3;
  localparam int CW          = $clog2(FRAME_BYTES + 1);
  localparam int FW          = FRAME_BYTES * DW;

  logic          take_irq, take_rti, in_push, in_vec, in_pull;
  logic [CW-1:0] step;
  logic [FW-1:0] frame_in, frame_out;

  assign frame_in = {ccr_in, b_in, a_in, x_in, y_in, pc_in};

  irq_stk_ctrl #(.FRAME_BYTES(FRAME_BYTES), .VEC_BYTES(WPB), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .rti_req(rti_req),
    .take_irq(take_irq), .take_rti(take_rti), .in_push(in_push),
    .in_vec(in_vec), .in_pull(in_pull), .step(step), .busy(busy), .done(done)
  );

  irq_stk_addr #(.AW(AW), .CW(CW)) u_addr (
    .clk(clk), .rst_n(rst_n), .take_irq(take_irq), .take_rti(take_rti),
    .in_push(in_push), .in_vec(in_vec), .in_pull(in_pull), .step(step),
    .sp_in(sp_in), .vec_in(irq_vec), .mem_addr(mem_addr), .sp_out(sp_out)
  );

  irq_stk_ctx #(.AW(AW), .DW(DW), .FRAME_BYTES(FRAME_BYTES), .CW(CW)) u_ctx (
    .clk(clk), .rst_n(rst_n), .take_irq(take_irq), .in_push(in_push),
    .in_vec(in_vec), .in_pull(in_pull), .step(step), .frame_in(frame_in),
    .rdata(mem_rdata), .wdata(mem_wdata), .we(mem_we), .frame_out(frame_out)
  );

  assign {ccr_out, b_out, a_out, x_out, y_out, pc_out} = frame_out;

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R10
  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && irq_req) |=> !(take_irq && !$past(done))); // R7
endmodule

// File: tb/irq_stacker_test.sv
module irq_stacker_test;
  logic clk = 1'b0;
  logic rst_n;
  logic irq_req, rti_req;
  logic [15:0] irq_vec, pc_in, y_in, x_in, sp_in;
  logic [7:0]  a_in, b_in, ccr_in;
  logic [15:0] mem_addr, pc_out, y_out, x_out, sp_out;
  logic [7:0]  mem_wdata, mem_rdata, a_out, b_out, ccr_out;
  logic        mem_we, busy, done;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0]  mem [256];
  logic [15:0] log_a [32];
  logic [7:0]  log_d [32];
  logic        log_w [32];
  int          nlog = 0;

  always #2.5 clk = ~clk;

  irq_stacker uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec), .rti_req(rti_req),
    .pc_in(pc_in), .y_in(y_in), .x_in(x_in), .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in),
    .sp_in(sp_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_we(mem_we), .busy(busy), .done(done), .pc_out(pc_out), .y_out(y_out),
    .x_out(x_out), .a_out(a_out), .b_out(b_out), .ccr_out(ccr_out), .sp_out(sp_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  always @(negedge clk) begin
    cycles++;
    if (busy && nlog < 32) begin
      log_a[nlog] = mem_addr; log_d[nlog] = mem_wdata; log_w[nlog] = mem_we; nlog++;
    end
    if (cycles > 100000) begin
      errors++; $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int k, input logic [15:0] p, input logic [15:0] y,
    input logic [15:0] x, input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    case (k)
      0: return p[7:0];  1: return p[15:8];
      2: return y[7:0];  3: return y[15:8];
      4: return x[7:0];  5: return x[15:8];
      6: return a;       7: return b;
      default: return c;
    endcase
  endfunction

  // Runs one sequence after the request has been driven; returns busy count.
  task automatic run_seq(input bit noise, output int nbusy);
    int guard = 0;
    nbusy = 0;
    @(negedge clk);
    irq_req = 1'b0; rti_req = 1'b0;
    while (!done && guard < 60) begin
      if (busy) nbusy++;
      irq_req = noise && (nbusy == 3 || nbusy == 4);
      rti_req = noise && (nbusy == 4 || nbusy == 5);
      @(negedge clk);
      guard++;
    end
    irq_req = 1'b0; rti_req = 1'b0;
  endtask

  task automatic do_pair(input logic [15:0] sp, input logic [15:0] vec, input int idx,
                         input bit noise, input bit both);
    logic [15:0] p, y, x, vval;
    logic [7:0]  a, b, c;
    int nb;
    p = 16'h1357 + 16'(idx * 16'h0913);
    y = 16'hA0B1 ^ 16'(idx * 16'h1111);
    x = 16'h4C2D + 16'(idx * 16'h0707);
    a = 8'h11 + 8'(idx * 3); b = 8'hE0 - 8'(idx * 5); c = 8'hC0 | 8'(idx);
    vval = 16'hB000 + 16'(idx * 16'h0123);
    mem[vec[7:0]] = vval[15:8];
    mem[8'(vec[7:0] + 8'd1)] = vval[7:0];
    pc_in = p; y_in = y; x_in = x; a_in = a; b_in = b; ccr_in = c; sp_in = sp; irq_vec = vec;
    nlog = 0;
    irq_req = 1'b1; rti_req = both;
    run_seq(noise, nb);
    chk("R5 irq busy cycles", nb, 11);
    chk("R7 cycles under requests", nlog, 11);
    chk("R5 done pulse", {busy, done}, 2'b01);
    for (int k = 0; k < 9; k++) begin
      chk("R2 push is write", log_w[k], 1'b1);
      chk("R3 push addr", log_a[k], 16'(sp - 16'(k)));
      chk("R2 push data", log_d[k], fbyte(k, p, y, x, a, b, c));
    end
    chk("R4 vec hi addr", {log_w[9], log_a[9]}, {1'b0, vec});
    chk("R10 vec lo addr wraps", {log_w[10], log_a[10]}, {1'b0, 16'(vec + 16'd1)});
    chk("R4 pc_out = vector", pc_out, vval);
    chk("R3 sp_out after irq", sp_out, 16'(sp - 16'd9));
    chk("R9 y,x kept", {y_out, x_out}, {y, x});
    chk("R9 a,b,ccr kept", {a_out, b_out, ccr_out}, {a, b, c});
    @(negedge clk);
    chk("R5 done one cycle", {busy, done, mem_we}, 3'b000);
    pc_in = ~p; y_in = ~y; x_in = ~x; a_in = ~a; b_in = ~b; ccr_in = ~c;
    sp_in = 16'(sp - 16'd9);
    nlog = 0;
    rti_req = 1'b1;
    run_seq(noise, nb);
    chk("R6 rti busy cycles", nb, 9);
    chk("R7 rti cycles under requests", nlog, 9);
    for (int j = 0; j < 9; j++) begin
      chk("R6 pull addr", {log_w[j], log_a[j]}, {1'b0, 16'(sp - 16'd8 + 16'(j))});
    end
    chk("R6 restored pc", pc_out, p);
    chk("R6 restored y,x", {y_out, x_out}, {y, x});
    chk("R6 restored a,b,ccr", {a_out, b_out, ccr_out}, {a, b, c});
    chk("R6 sp_out after rti", sp_out, sp);
    @(negedge clk);
    chk("R7 idle after rti", {busy, done}, 2'b00);
  endtask

  initial begin
    rst_n = 1'b0; irq_req = 1'b0; rti_req = 1'b0; irq_vec = '0;
    pc_in = '0; y_in = '0; x_in = '0; a_in = '0; b_in = '0; ccr_in = '0; sp_in = '0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7);
    repeat (3) @(negedge clk);
    chk("R8 reset outputs", {busy, done, mem_we}, 3'b000);
    irq_req = 1'b1; rti_req = 1'b1;
    @(negedge clk);
    chk("R8 reset holds idle", {busy, done, mem_we}, 3'b000);
    irq_req = 1'b0; rti_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after release", {busy, done}, 2'b00);
    do_pair(16'h0080, 16'hFFF0, 0, 1'b0, 1'b0);
    do_pair(16'h0004, 16'hFFF0, 1, 1'b0, 1'b0); // R10 stack wraps through zero
    do_pair(16'h00FF, 16'hFFF0, 2, 1'b1, 1'b0); // R7 requests during busy
    do_pair(16'h1234, 16'hFFF0, 3, 1'b0, 1'b1); // R1 both requests, irq wins
    do_pair(16'h0080, 16'hFFFF, 4, 1'b0, 1'b0); // R10 vector low byte at 0000
    do_pair(16'h8050, 16'h2040, 5, 1'b1, 1'b1);
    rti_req = 1'b1;
    @(negedge clk);
    rti_req = 1'b0;
    chk("R1 rti alone accepted", busy, 1'b1);
    repeat (12) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule